// File: doc/BRIEF.md
# Operand Effective-Address Resolver

This block resolves one instruction operand. It takes an addressing-mode code, two register indices (base and index), a 32-bit literal, a scale selector and an access-size selector. From these it produces either an operand value or a memory effective address. It reads the two registers through combinational read ports of an external register file. Only one mode reads memory, and it does so through a simple request/valid channel. For the post-increment and post-decrement modes it also returns a base-register writeback. Instruction decoding, the data access itself and protection checks belong to other blocks.

A request is accepted when `go` is high and the block is idle. The control is a two-state machine:
- `ST_IDLE` accepts requests. `ST_IDLE -> ST_IDLE` resolves every single-step mode, and `done` rises on the next cycle.
- `ST_IDLE -> ST_FETCH` is taken for the memory-indirect mode. `ST_FETCH` holds a pointer read request until the memory answers.
- `ST_FETCH -> ST_IDLE` completes the request when read data is valid.

While the block is in `ST_FETCH`, new requests are ignored.

Top module: `eff_addr_unit`

## Requirements
- R1: While reset is held and on the first cycle after it, `done`, `illegal`, `wb_en` and `ptr_req` are all low.
- R2: Mode 1 (register value) returns the base register's contents as an operand. Mode 2 (literal) returns `lit` as an operand. In both cases `is_addr`=0 and no memory read is issued.
- R3: The remaining address modes return `is_addr`=1, with the address formed as follows: mode 3 gives base+lit, mode 4 gives base, mode 6 gives lit, and mode 5 gives base+index.
- R4: Mode 10 (scaled) gives base + index*2^`scale_sel` + lit, where `scale_sel` 0..3 means a factor of 1, 2, 4 or 8.
- R5: Every mode other than 7 raises `done` for one cycle on the cycle after the accepting edge.
- R6: Mode 7 (pointer-indirect) raises `ptr_req` with `ptr_addr` equal to the base register. Both stay steady until `ptr_valid` is seen. On the cycle after that edge, `done` rises, `result` equals the returned `ptr_data` and `is_addr`=1.
- R7: Mode 8 (post-increment) and mode 9 (post-decrement) return the old base as the address. In the `done` cycle they assert `wb_en` with `wb_idx` equal to the base index and `wb_data` equal to base ± 2^`size_sel` bytes.
- R8: Codes 0 and 11..15 complete with `done` and `illegal`=1, `is_addr`=0, `result`=0, no writeback and no memory read.
- R9: A `go` presented while `ptr_req` is high has no effect. No extra `done` follows, and the pending result is unchanged.
- R10: All sums and differences wrap modulo 2^32.
- R11: A request accepted in the same cycle that `done` is high is served immediately, so single-step requests can complete back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go | input | 1 | Request strobe |
| mode | input | 4 | Addressing-mode code |
| base_idx | input | 4 | Base register index |
| index_idx | input | 4 | Index register index |
| lit | input | 32 | Literal / displacement |
| scale_sel | input | 2 | Index scale, factor 2^scale_sel |
| size_sel | input | 2 | Access size, 2^size_sel bytes |
| rf_a_idx | output | 4 | Register read port A index |
| rf_a_data | input | 32 | Register read port A data |
| rf_b_idx | output | 4 | Register read port B index |
| rf_b_data | input | 32 | Register read port B data |
| ptr_req | output | 1 | Pointer read request |
| ptr_addr | output | 32 | Pointer read address |
| ptr_valid | input | 1 | Pointer read data valid |
| ptr_data | input | 32 | Pointer read data |
| done | output | 1 | Request complete (one cycle) |
| is_addr | output | 1 | Result is an address, not an operand |
| illegal | output | 1 | Mode code was not legal |
| result | output | 32 | Resolved address or operand |
| wb_en | output | 1 | Base writeback enable |
| wb_idx | output | 4 | Base writeback index |
| wb_data | output | 32 | Base writeback value |

## Verification
Each mode is driven with base and index registers holding distinct, unrelated values, so that swapping operands or dropping one term shows up in the result. The scaled mode is run at all four scale selections, and the step modes at several sizes, to separate a shift amount from a factor. Values near 2^32 confirm wraparound. The pointer-indirect mode is run with memory latencies of zero and several cycles, and with a stray request during the wait. Illegal codes from both ends of the range and a back-to-back pair of requests complete the set.

// File: rtl/eau_pkg.sv
package eau_pkg;
    localparam logic [3:0] AM_REG  = 4'd1;
    localparam logic [3:0] AM_LIT  = 4'd2;
    localparam logic [3:0] AM_DISP = 4'd3;
    localparam logic [3:0] AM_RIND = 4'd4;
    localparam logic [3:0] AM_IDX  = 4'd5;
    localparam logic [3:0] AM_ABS  = 4'd6;
    localparam logic [3:0] AM_PTR  = 4'd7;
    localparam logic [3:0] AM_PINC = 4'd8;
    localparam logic [3:0] AM_PDEC = 4'd9;
    localparam logic [3:0] AM_SCL  = 4'd10;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_FETCH = 1'b1
    } eau_state_e;
endpackage

// File: rtl/eau_calc.sv
module eau_calc
    import eau_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [3:0]   mode,
    input  logic [W-1:0] ra,
    input  logic [W-1:0] rb,
    input  logic [W-1:0] lit,
    input  logic [1:0]   scale_sel,
    input  logic [1:0]   size_sel,
    output logic         c_illegal,
    output logic         c_is_addr,
    output logic         c_need_mem,
    output logic         c_wb_en,
    output logic [W-1:0] c_value,
    output logic [W-1:0] c_wb_val
);
    logic [W-1:0] step;
    logic [W-1:0] scaled;

    assign step   = W'(1) << size_sel;
    assign scaled = rb << scale_sel;

    always_comb begin
        c_illegal  = 1'b0;
        c_is_addr  = 1'b1;
        c_need_mem = 1'b0;
        c_wb_en    = 1'b0;
        c_value    = '0;
        c_wb_val   = '0;
        case (mode)
            AM_REG: begin
                c_is_addr = 1'b0;
                c_value   = ra;
            end
            AM_LIT: begin
                c_is_addr = 1'b0;
                c_value   = lit;
            end
            AM_DISP: c_value = ra + lit;
            AM_RIND: c_value = ra;
            AM_IDX:  c_value = ra + rb;
            AM_ABS:  c_value = lit;
            AM_PTR: begin
                c_need_mem = 1'b1;
                c_value    = ra;
            end
            AM_PINC: begin
                c_value  = ra;
                c_wb_en  = 1'b1;
                c_wb_val = ra + step;
            end
            AM_PDEC: begin
                c_value  = ra;
                c_wb_en  = 1'b1;
                c_wb_val = ra - step;
            end
            AM_SCL:  c_value = ra + scaled + lit;
            default: begin
                c_illegal = 1'b1;
                c_is_addr = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/eau_fsm.sv
module eau_fsm
    import eau_pkg::*;
#(
    parameter int W     = 32,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [IDX_W-1:0] base_idx,
    input  logic             c_illegal,
    input  logic             c_is_addr,
    input  logic             c_need_mem,
    input  logic             c_wb_en,
    input  logic [W-1:0]     c_value,
    input  logic [W-1:0]     c_wb_val,
    input  logic             ptr_valid,
    input  logic [W-1:0]     ptr_data,
    output logic             ptr_req,
    output logic [W-1:0]     ptr_addr,
    output logic             done,
    output logic             is_addr,
    output logic             illegal,
    output logic [W-1:0]     result,
    output logic             wb_en,
    output logic [IDX_W-1:0] wb_idx,
    output logic [W-1:0]     wb_data
);
    eau_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (go && c_need_mem) state_d = ST_FETCH;
            ST_FETCH: if (ptr_valid)        state_d = ST_IDLE;
        endcase
    end

    assign ptr_req = (state_q == ST_FETCH);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done     <= 1'b0;
            is_addr  <= 1'b0;
            illegal  <= 1'b0;
            result   <= '0;
            wb_en    <= 1'b0;
            wb_idx   <= '0;
            wb_data  <= '0;
            ptr_addr <= '0;
        end else begin
            done    <= 1'b0;
            illegal <= 1'b0;
            wb_en   <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (go && c_need_mem) begin
                        ptr_addr <= c_value;
                    end else if (go) begin
                        done    <= 1'b1;
                        is_addr <= c_is_addr;
                        illegal <= c_illegal;
                        result  <= c_value;
                        wb_en   <= c_wb_en;
                        wb_idx  <= base_idx;
                        wb_data <= c_wb_val;
                    end
                end
                ST_FETCH: begin
                    if (ptr_valid) begin
                        done    <= 1'b1;
                        is_addr <= 1'b1;
                        result  <= ptr_data;
                    end
                end
            endcase
        end
    end

    // R6
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FETCH && !ptr_valid) |=> (ptr_req && $stable(ptr_addr)));

    // R6
    ptr_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_req && ptr_valid) |=> (done && is_addr && result == $past(ptr_data)));

    // R7
    wb_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> done);

    // R8
    illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (done && !wb_en && !is_addr && result == '0));
endmodule

// File: rtl/eff_addr_unit.sv
module eff_addr_unit
    import eau_pkg::*;
#(
    parameter int W     = 32,
    parameter int NREG  = 16,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [3:0]       mode,
    input  logic [IDX_W-1:0] base_idx,
    input  logic [IDX_W-1:0] index_idx,
    input  logic [W-1:0]     lit,
    input  logic [1:0]       scale_sel,
    input  logic [1:0]       size_sel,
    output logic [IDX_W-1:0] rf_a_idx,
    input  logic [W-1:0]     rf_a_data,
    output logic [IDX_W-1:0] rf_b_idx,
    input  logic [W-1:0]     rf_b_data,
    output logic             ptr_req,
    output logic [W-1:0]     ptr_addr,
    input  logic             ptr_valid,
    input  logic [W-1:0]     ptr_data,
    output logic             done,
    output logic             is_addr,
    output logic             illegal,
    output logic [W-1:0]     result,
    output logic             wb_en,
    output logic [IDX_W-1:0] wb_idx,
    output logic [W-1:0]     wb_data
);
    logic         c_illegal, c_is_addr, c_need_mem, c_wb_en;
    logic [W-1:0] c_value, c_wb_val;

    assign rf_a_idx = base_idx;
    assign rf_b_idx = index_idx;

    eau_calc #(.W(W)) u_calc (
        .mode       (mode),
        .ra         (rf_a_data),
        .rb         (rf_b_data),
        .lit        (lit),
        .scale_sel  (scale_sel),
        .size_sel   (size_sel),
        .c_illegal  (c_illegal),
        .c_is_addr  (c_is_addr),
        .c_need_mem (c_need_mem),
        .c_wb_en    (c_wb_en),
        .c_value    (c_value),
        .c_wb_val   (c_wb_val)
    );

    eau_fsm #(.W(W), .IDX_W(IDX_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (go),
        .base_idx   (base_idx),
        .c_illegal  (c_illegal),
        .c_is_addr  (c_is_addr),
        .c_need_mem (c_need_mem),
        .c_wb_en    (c_wb_en),
        .c_value    (c_value),
        .c_wb_val   (c_wb_val),
        .ptr_valid  (ptr_valid),
        .ptr_data   (ptr_data),
        .ptr_req    (ptr_req),
        .ptr_addr   (ptr_addr),
        .done       (done),
        .is_addr    (is_addr),
        .illegal    (illegal),
        .result     (result),
        .wb_en      (wb_en),
        .wb_idx     (wb_idx),
        .wb_data    (wb_data)
    );

    // R5
    single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (go && !ptr_req && mode != AM_PTR) |=> done);

    // R9
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_req && !ptr_valid) |=> !done);

    // R2
    operand_no_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (go && !ptr_req && (mode == AM_REG || mode == AM_LIT)) |=> (!ptr_req && !is_addr));
endmodule

// File: tb/eff_addr_unit_bench.sv
module eff_addr_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        go = 1'b0;
    logic [3:0]  mode = '0;
    logic [3:0]  base_idx = '0, index_idx = '0;
    logic [31:0] lit = '0;
    logic [1:0]  scale_sel = '0, size_sel = '0;
    logic [3:0]  rf_a_idx, rf_b_idx;
    logic [31:0] rf_a_data, rf_b_data;
    logic        ptr_req, ptr_valid = 1'b0;
    logic [31:0] ptr_addr, ptr_data = '0;
    logic        done, is_addr, illegal, wb_en;
    logic [31:0] result, wb_data;
    logic [3:0]  wb_idx;

    logic [31:0] hw_rf [16];
    logic [31:0] exp_rf [16];
    int n_vec = 0, n_bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    assign rf_a_data = hw_rf[rf_a_idx];
    assign rf_b_data = hw_rf[rf_b_idx];

    always @(posedge clk) if (wb_en) hw_rf[wb_idx] <= wb_data;

    eff_addr_unit u_eff_addr_unit (
        .clk(clk), .rst_n(rst_n), .go(go), .mode(mode),
        .base_idx(base_idx), .index_idx(index_idx), .lit(lit),
        .scale_sel(scale_sel), .size_sel(size_sel),
        .rf_a_idx(rf_a_idx), .rf_a_data(rf_a_data),
        .rf_b_idx(rf_b_idx), .rf_b_data(rf_b_data),
        .ptr_req(ptr_req), .ptr_addr(ptr_addr),
        .ptr_valid(ptr_valid), .ptr_data(ptr_data),
        .done(done), .is_addr(is_addr), .illegal(illegal), .result(result),
        .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data)
    );

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return {a[15:0], a[31:16]} ^ 32'h5A5A_0F0F;
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        n_vec++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
        end
    endtask

    // Reference model: expected outcome of one request
    task automatic model(input logic [3:0] m, input int bi, input int xi,
                         input logic [31:0] n, input logic [1:0] sc, input logic [1:0] sz,
                         output logic [31:0] val, output logic ad, output logic il,
                         output logic we, output logic [31:0] wv);
        logic [31:0] ra, rb;
        longint unsigned stepb, fac;
        ra = exp_rf[bi]; rb = exp_rf[xi];
        stepb = 1; for (int k = 0; k < sz; k++) stepb = stepb * 2;
        fac = 1;   for (int k = 0; k < sc; k++) fac = fac * 2;
        val = 0; ad = 1; il = 0; we = 0; wv = 0;
        case (m)
            1: begin val = ra; ad = 0; end
            2: begin val = n; ad = 0; end
            3: val = 32'(longint'(ra) + longint'(n));
            4: val = ra;
            5: val = 32'(longint'(ra) + longint'(rb));
            6: val = n;
            7: val = mem_word(ra);
            8: begin val = ra; we = 1; wv = 32'(longint'(ra) + longint'(stepb)); end
            9: begin val = ra; we = 1; wv = 32'(longint'(ra) - longint'(stepb)); end
            10: val = 32'(longint'(ra) + longint'(rb) * longint'(fac) + longint'(n));
            default: begin il = 1; ad = 0; end
        endcase
    endtask

    task automatic drive(input logic [3:0] m, input int bi, input int xi,
                         input logic [31:0] n, input logic [1:0] sc, input logic [1:0] sz);
        go = 1; mode = m; base_idx = 4'(bi); index_idx = 4'(xi);
        lit = n; scale_sel = sc; size_sel = sz;
    endtask

    task automatic check_done(input string req, input logic [31:0] val, input logic ad,
                              input logic il, input logic we, input int bi, input logic [31:0] wv);
        chk(req, "done", 32'(done), 1);
        chk(req, "result", result, val);
        chk(req, "is_addr", 32'(is_addr), 32'(ad));
        chk(req, "illegal", 32'(illegal), 32'(il));
        chk(req, "wb_en", 32'(wb_en), 32'(we));
        chk(req, "ptr_req", 32'(ptr_req), 0);
        if (we) begin
            chk(req, "wb_idx", 32'(wb_idx), 32'(bi));
            chk(req, "wb_data", wb_data, wv);
            exp_rf[bi] = wv;
        end
    endtask

    task automatic run_op(input string req, input logic [3:0] m, input int bi, input int xi,
                          input logic [31:0] n, input logic [1:0] sc, input logic [1:0] sz,
                          input int lat);
        logic [31:0] val, wv; logic ad, il, we;
        model(m, bi, xi, n, sc, sz, val, ad, il, we, wv);
        @(negedge clk); drive(m, bi, xi, n, sc, sz);
        @(negedge clk); go = 0;
        if (m == 4'd7) begin
            chk(req, "ptr_req", 32'(ptr_req), 1);
            chk(req, "ptr_addr", ptr_addr, exp_rf[bi]);
            chk(req, "done early", 32'(done), 0);
            for (int k = 0; k < lat; k++) begin
                @(negedge clk);
                chk(req, "ptr_req held", 32'(ptr_req), 1);
                chk(req, "ptr_addr held", ptr_addr, exp_rf[bi]);
                chk(req, "done early", 32'(done), 0);
            end
            ptr_valid = 1; ptr_data = mem_word(ptr_addr);
            @(negedge clk); ptr_valid = 0;
        end
        check_done(req, val, ad, il, we, bi, wv);
    endtask

    initial begin
        #(20 * 5000);
        chk("WDOG", "watchdog expired", 1, 0);
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) begin
            hw_rf[i]  = 32'h1000_0000 * 32'(i) + 32'h0000_0137 * 32'(i + 1);
            exp_rf[i] = hw_rf[i];
        end
        hw_rf[12] = 32'hFFFF_FFF0; exp_rf[12] = 32'hFFFF_FFF0;
        hw_rf[13] = 32'h0000_0000; exp_rf[13] = 32'h0000_0000;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1", "done in reset", 32'(done), 0);
        chk("R1", "ptr_req in reset", 32'(ptr_req), 0);
        rst_n = 1;
        @(negedge clk);
        chk("R1", "done", 32'(done), 0);
        chk("R1", "illegal", 32'(illegal), 0);
        chk("R1", "wb_en", 32'(wb_en), 0);
        chk("R1", "ptr_req", 32'(ptr_req), 0);

        // R2: operand modes
        run_op("R2", 4'd1, 3, 5, 32'hDEAD_0001, 0, 0, 0);
        run_op("R2", 4'd2, 3, 5, 32'hCAFE_F00D, 0, 0, 0);
        // R3: address modes; R5 single-step timing checked in every run
        run_op("R3", 4'd3, 4, 6, 32'h0000_0044, 0, 0, 0);
        run_op("R3", 4'd4, 7, 6, 32'h1234_5678, 0, 0, 0);
        run_op("R3", 4'd5, 2, 9, 32'h0000_0000, 0, 0, 0);
        run_op("R5", 4'd6, 2, 9, 32'h0BAD_BEEF, 0, 0, 0);
        // R4: scaled at all factors
        for (int s = 0; s < 4; s++) run_op("R4", 4'd10, 1, 3, 32'h0000_0100, 2'(s), 0, 0);
        // R6: pointer indirect, several latencies
        run_op("R6", 4'd7, 5, 0, 0, 0, 0, 0);
        run_op("R6", 4'd7, 8, 0, 0, 0, 0, 4);
        // R7: post-increment / post-decrement, several sizes
        run_op("R7", 4'd8, 6, 0, 0, 0, 2'd0, 0);
        run_op("R7", 4'd8, 6, 0, 0, 0, 2'd3, 0);
        run_op("R7", 4'd9, 6, 0, 0, 0, 2'd2, 0);
        run_op("R7", 4'd4, 6, 0, 0, 0, 0, 0);
        // R10: wraparound
        run_op("R10", 4'd3, 12, 0, 32'h0000_0020, 0, 0, 0);
        run_op("R10", 4'd9, 13, 0, 0, 0, 2'd3, 0);
        run_op("R10", 4'd4, 13, 0, 0, 0, 0, 0);
        run_op("R10", 4'd8, 12, 0, 0, 0, 2'd3, 0);
        // R8: illegal codes
        run_op("R8", 4'd0, 1, 2, 32'h5555_5555, 0, 0, 0);
        run_op("R8", 4'd11, 1, 2, 32'h5555_5555, 0, 0, 0);
        run_op("R8", 4'd15, 1, 2, 32'h5555_5555, 0, 3, 0);
        @(negedge clk);
        chk("R8", "no ptr_req after illegal", 32'(ptr_req), 0);

        // R9: request during pointer wait is ignored
        begin
            logic [31:0] pa;
            @(negedge clk); drive(4'd7, 9, 0, 0, 0, 0);
            @(negedge clk); drive(4'd8, 2, 0, 0, 0, 0);
            pa = exp_rf[9];
            chk("R9", "ptr_addr", ptr_addr, pa);
            @(negedge clk); go = 0;
            chk("R9", "done during wait", 32'(done), 0);
            chk("R9", "wb_en during wait", 32'(wb_en), 0);
            @(negedge clk);
            chk("R9", "done during wait", 32'(done), 0);
            ptr_valid = 1; ptr_data = mem_word(pa);
            @(negedge clk); ptr_valid = 0;
            chk("R9", "done", 32'(done), 1);
            chk("R9", "result", result, mem_word(pa));
            chk("R9", "wb_en", 32'(wb_en), 0);
            @(negedge clk);
            chk("R9", "no stray done", 32'(done), 0);
            chk("R9", "reg untouched", hw_rf[2], exp_rf[2]);
        end

        // R11: back-to-back single-step requests
        begin
            logic [31:0] v1, v2, w1, w2; logic a1, a2, i1, i2, e1, e2;
            model(4'd3, 10, 0, 32'h10, 0, 0, v1, a1, i1, e1, w1);
            model(4'd8, 11, 0, 0, 0, 2'd1, v2, a2, i2, e2, w2);
            @(negedge clk); drive(4'd3, 10, 0, 32'h10, 0, 0);
            @(negedge clk); drive(4'd8, 11, 0, 0, 0, 2'd1);
            check_done("R11", v1, a1, i1, e1, 10, w1);
            @(negedge clk); go = 0;
            check_done("R11", v2, a2, i2, e2, 11, w2);
            @(negedge clk);
            chk("R11", "done drops", 32'(done), 0);
            chk("R11", "wb applied", hw_rf[11], exp_rf[11]);
        end

        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule